// File: doc/BRIEF.md
# Fractional Pulse Rate Divider (25/16)

This block thins a stream of single-cycle input strobes so that, out of every 25 strobes, 16 are forwarded and 9 are dropped, for an average rate division of 25/16 (1.5625). Placed behind a fixed divide-by-64 stage, the two together divide by exactly 100. Input events reach the block as a one-cycle strobe on the system clock, at a rate below 50 MHz.

The pass/drop decision comes from a phase accumulator: each strobe adds 16 modulo 25, and a strobe is forwarded when that addition wraps. The forwarded strobes are therefore spread as evenly as the ratio allows. A separate modulo-25 position counter advances on every input strobe, whether it is forwarded or dropped. It raises a one-cycle frame marker each time it returns to zero.

Top module: `frac_pulse_thinner`

## Requirements
- R1: While `rst` is high on a clock edge, both outputs are low in the next cycle, and the accumulator and the position counter are set to 0. Input strobes seen during reset have no effect. Because of this, the first strobe after reset is dropped and the second is forwarded.
- R2: Each group of 25 consecutive input strobes, counted from reset, produces exactly 16 output strobes.
- R3: Count input strobes from reset as k = 1, 2, .... Strobe k is forwarded exactly when floor(16k/25) > floor(16(k-1)/25). As a result, two consecutive strobes are never both dropped.
- R4: A forwarded strobe that is sampled on a clock edge raises `out_stb` for exactly one cycle, in the cycle that follows that edge.
- R5: Cycles with `in_stb` low produce no output strobe and leave the forwarding pattern unchanged.
- R6: Strobes on consecutive clock cycles are each processed. None is merged with another or lost.
- R7: `frame_end` is high for one cycle in the cycle after every 25th input strobe (k a multiple of 25), and is low at all other times.
- R8: Over many frames the ratio does not drift. After 25·n strobes, exactly 16·n outputs have been produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| in_stb | input | 1 | Input event strobe, one cycle per event |
| out_stb | output | 1 | Forwarded event strobe, registered |
| frame_end | output | 1 | Marks completion of each 25-strobe frame |

## Verification
The assertions assume that `in_stb` is a clean, fully synchronous level that is sampled once per edge, with every high cycle counting as one event. They also assume that frames are counted from the most recent reset. The checker keeps its own counts of forwarded strobes per frame and of consecutive drops, and it compares these with the frame marker. The bench drives `in_stb` only at falling edges, never while it samples outputs. It mixes unbroken runs of strobes, sparse strobes with idle gaps, and a reset in the middle of a frame, so that the frame counts stay aligned with reset.

// File: rtl/frac_pulse_thinner.sv
module frac_pulse_thinner #(
  parameter int unsigned DEN = 25,
  parameter int unsigned NUM = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic in_stb,
  output logic out_stb,
  output logic frame_end
);
  localparam int unsigned AW = $clog2(DEN);
  localparam logic [AW:0] NUM_W = (AW+1)'(NUM);
  localparam logic [AW:0] DEN_W = (AW+1)'(DEN);
  localparam logic [AW-1:0] LAST = AW'(DEN - 1);

  logic [AW-1:0] acc, pos;
  logic [AW:0]   sum, sum_wr;
  logic          wrap;

  assign sum    = {1'b0, acc} + NUM_W;
  assign wrap   = sum >= DEN_W;
  assign sum_wr = wrap ? sum - DEN_W : sum;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc       <= '0;
      pos       <= '0;
      out_stb   <= 1'b0;
      frame_end <= 1'b0;
    end else begin
      out_stb   <= in_stb && wrap;
      frame_end <= in_stb && (pos == LAST);
      if (in_stb) begin
        acc <= sum_wr[AW-1:0];
        pos <= (pos == LAST) ? '0 : pos + 1'b1;
      end
    end
  end
endmodule

// File: rtl/frac_pulse_thinner_chk.sv
module frac_pulse_thinner_chk #(
  parameter int unsigned NUM = 16
) (
  input logic clk,
  input logic rst,
  input logic in_stb,
  input logic out_stb,
  input logic frame_end
);
  logic [7:0] pass_cnt;
  logic [1:0] miss_cnt;
  logic       in_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      pass_cnt <= '0;
      miss_cnt <= '0;
      in_d     <= 1'b0;
    end else begin
      in_d     <= in_stb;
      pass_cnt <= frame_end ? 8'd0 : pass_cnt + {7'd0, out_stb};
      if (out_stb)   miss_cnt <= '0;
      else if (in_d) miss_cnt <= miss_cnt + 2'd1;
    end
  end

  AST_OUT_FOLLOWS_IN: assert property (@(posedge clk) disable iff (rst) out_stb |-> in_d); // R4
  AST_OUT_ONE_WIDE: assert property (@(posedge clk) disable iff (rst) (out_stb && !in_stb) |=> !out_stb); // R4
  AST_FRAME_FOLLOWS_IN: assert property (@(posedge clk) disable iff (rst) frame_end |-> in_d); // R7
  AST_FRAME_ONE_WIDE: assert property (@(posedge clk) disable iff (rst) frame_end |=> !frame_end); // R7
  AST_SIXTEEN_PER_FRAME: assert property (@(posedge clk) disable iff (rst) frame_end |-> (pass_cnt + {7'd0, out_stb}) == 8'(NUM)); // R2
  AST_NO_DOUBLE_DROP: assert property (@(posedge clk) disable iff (rst) (in_d && !out_stb) |-> miss_cnt == 2'd0); // R3
endmodule

bind frac_pulse_thinner frac_pulse_thinner_chk #(.NUM(NUM)) chk_i (
  .clk(clk), .rst(rst), .in_stb(in_stb), .out_stb(out_stb), .frame_end(frame_end)
);

// File: tb/frac_pulse_thinner_tb_top.sv
`timescale 1ns/1ps
module frac_pulse_thinner_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_stb = 1'b0;
  logic out_stb, frame_end;

  int n_chk = 0, n_bad = 0;
  int k = 0;
  int total_out = 0;
  int frame_out = 0;

  always #2.5 clk = ~clk;

  frac_pulse_thinner dut_i (
    .clk(clk), .rst(rst), .in_stb(in_stb), .out_stb(out_stb), .frame_end(frame_end)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (strobe %0d)", req, act, exp, k);
    end
  endtask

  task automatic step(input bit s, input string req);
    bit ep, ef;
    in_stb = s;
    @(negedge clk);
    ep = 1'b0; ef = 1'b0;
    if (s) begin
      k++;
      ep = ((16 * k) / 25) != ((16 * (k - 1)) / 25);
      ef = (k % 25) == 0;
    end
    check({req, " out_stb"}, int'(out_stb), int'(ep));
    check("R7 frame_end", int'(frame_end), int'(ef));
    if (out_stb) begin total_out++; frame_out++; end
    if (frame_end) begin
      check("R2 per-frame passes", frame_out, 16);
      frame_out = 0;
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    in_stb = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R1 out_stb in reset", int'(out_stb), 0);
    check("R1 frame_end in reset", int'(frame_end), 0);
    rst = 1'b0;
    in_stb = 1'b0;
    k = 0; total_out = 0; frame_out = 0;
  endtask

  task automatic t_reset_pattern();
    do_reset();
    step(1'b1, "R1 first strobe dropped");
    step(1'b1, "R1 second strobe passed");
  endtask

  task automatic t_back_to_back();
    do_reset();
    for (int i = 0; i < 100; i++) step(1'b1, "R6 back-to-back");
    check("R8 total after 4 frames", total_out, 64);
  endtask

  task automatic t_sparse();
    do_reset();
    for (int i = 0; i < 60; i++) begin
      step(1'b1, "R3 sparse");
      for (int j = 0; j < (i % 3); j++) step(1'b0, "R5 idle");
    end
  endtask

  task automatic t_idle_hold();
    do_reset();
    step(1'b1, "R3");
    step(1'b1, "R3");
    step(1'b1, "R3");
    for (int j = 0; j < 10; j++) step(1'b0, "R5 idle no output");
    step(1'b1, "R5 pattern kept after idle");
    step(1'b1, "R5 pattern kept after idle");
  endtask

  task automatic t_mid_reset();
    do_reset();
    for (int i = 0; i < 13; i++) step(1'b1, "R3");
    t_reset_pattern();
  endtask

  task automatic t_long_run();
    do_reset();
    for (int i = 0; i < 2500; i++) step(1'b1, "R8 long run");
    check("R8 total after 100 frames", total_out, 1600);
  endtask

  initial begin
    @(negedge clk);
    t_reset_pattern();
    t_back_to_back();
    t_sparse();
    t_idle_hold();
    t_mid_reset();
    t_long_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule